// File: doc/BRIEF.md
# Quadrature XOR Lock Detector

This block tells whether a loop built around an XOR phase detector has actually locked. An XOR detector on its own always produces some average output, so that output cannot show lock. The block solves this with a second XOR that runs a quarter cycle away from the first. A synchronous oscillator-edge strobe steps a two-bit walking-ring divider. The divider gives an in-phase tap and a quadrature tap at one quarter of the strobe rate. The in-phase tap drives the main detector, whose registered output goes to the loop filter. The quadrature tap is XORed with the reference. When the loop settles, the reference lines up with the quadrature tap, and the quadrature product is then almost always 0 (or almost always 1, depending on where the loop settles).

The block counts the quadrature product over fixed windows of 2^W system clocks and compares each window total against a threshold. The threshold is chosen from the tolerated phase variance, and the window is kept no shorter than the loop filter response. Separate acquire and hold thresholds give hysteresis. Several passing windows in a row are needed to raise the flag, and one bad window drops it. A loop that is slipping cycles near lock spreads the product towards 50 % duty, so it never collects the passing windows it needs.

Top module: `quad_lock_det`

## Requirements
- R1: The divider state `{tap_q, tap_i}` resets to 00. Each clock with `osc_tick`=1 it steps 00→01→11→10→00, and with `osc_tick`=0 it holds. `tap_q` therefore lags `tap_i` by one strobe, which is 90 degrees of the divided wave.
- R2: `pd_out` is the XOR of `ref_in` and `tap_i`, registered: it shows the value sampled at the previous clock edge.
- R3: Windows of 2^W clocks follow one another without overlap, starting with the first clock after reset. Each window total is the number of clocks in it on which `ref_in` XOR `tap_q` was 1.
- R4: With `pol`=0, a window passes when its total is strictly less than the active threshold. With `pol`=1, it passes when its total is strictly greater. A total equal to the threshold fails in both cases.
- R5: The active threshold is `thr_acq` while `lock` is 0 and `thr_hold` while `lock` is 1.
- R6: `lock` rises one clock after the window result that completes `LOCK_WINS` consecutive passing windows. A window result becomes available one clock after the window's last sample.
- R7: A single failing window clears `lock` and restarts the run of passing windows.
- R8: After reset, `lock` and `pd_out` are 0 and both taps are 0.
- R9: A reference at a different frequency (a slipping loop) never asserts `lock` at a threshold of a quarter window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_tick | input | 1 | One-clock strobe per oscillator rising edge |
| ref_in | input | 1 | Reference square wave, synchronous to clk |
| pol | input | 1 | 0: lock means few product ones; 1: lock means many |
| thr_acq | input | WIN_LOG2+1 | Threshold used while unlocked |
| thr_hold | input | WIN_LOG2+1 | Threshold used while locked |
| tap_i | output | 1 | In-phase divider tap |
| tap_q | output | 1 | Quadrature divider tap |
| pd_out | output | 1 | Registered main phase detector output |
| lock | output | 1 | Lock flag |

## Verification
The hardest case to reach is the hysteresis band: a window total that lies between the two thresholds, which must keep an existing lock but must not start one. Random reference noise lands on such a total only by chance. The stimulus therefore injects exactly k mismatches at the start of every window, counted by the bench's own window phase. It first holds the flag with k inside the band, then raises k to equal the threshold to force a drop, and then shows that the same in-band k cannot bring the flag back.

// File: rtl/qld_pkg.sv
package qld_pkg;
  typedef enum logic {
    POL_FEW  = 1'b0,
    POL_MANY = 1'b1
  } pol_e;

  // strict comparison against the threshold in the chosen direction
  function automatic logic win_ok(input pol_e p, input logic [15:0] total,
                                  input logic [15:0] thr);
    return (p == POL_MANY) ? (total > thr) : (total < thr);
  endfunction
endpackage

// File: rtl/qld_johnson.sv
module qld_johnson (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic ph_i,
  output logic ph_q
);
  logic [1:0] ring_q, ring_d;

  always_comb begin
    ring_d = ring_q;
    if (step) ring_d = {ring_q[0], ~ring_q[1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= 2'b00;
    else        ring_q <= ring_d;
  end

  assign ph_i = ring_q[0];
  assign ph_q = ring_q[1];

  p_one_bit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ($countones(ring_q ^ $past(ring_q)) == 1));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ring_q));
endmodule

// File: rtl/qld_window.sv
module qld_window #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  output logic         done,
  output logic [W:0]   total
);
  logic [W-1:0] phase_q, phase_d;
  logic [W:0]   acc_q, acc_d, sum_w;
  logic         done_d;
  logic [W:0]   total_d;

  assign sum_w = acc_q + {{W{1'b0}}, hit};

  always_comb begin
    phase_d = phase_q + 1'b1;
    done_d  = &phase_q;
    total_d = total;
    acc_d   = sum_w;
    if (&phase_q) begin
      total_d = sum_w;
      acc_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      acc_q   <= '0;
      done    <= 1'b0;
      total   <= '0;
    end else begin
      phase_q <= phase_d;
      acc_q   <= acc_d;
      done    <= done_d;
      total   <= total_d;
    end
  end

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_total_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (total <= (W+1)'(1 << W)));
endmodule

// File: rtl/qld_lock_fsm.sv
module qld_lock_fsm
  import qld_pkg::*;
#(
  parameter int W    = 4,
  parameter int WINS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic [W:0] total,
  input  logic       pol,
  input  logic [W:0] thr_acq,
  input  logic [W:0] thr_hold,
  output logic       lock
);
  localparam int RW = (WINS > 1) ? $clog2(WINS) : 1;

  logic [RW-1:0] run_q, run_d;
  logic          lock_d;
  logic [W:0]    thr_sel;
  logic          pass;

  assign thr_sel = lock ? thr_hold : thr_acq;
  assign pass    = win_ok(pol_e'(pol), 16'(total), 16'(thr_sel));

  always_comb begin
    run_d  = run_q;
    lock_d = lock;
    if (done) begin
      if (!pass) begin
        run_d  = '0;
        lock_d = 1'b0;
      end else if (!lock) begin
        if (run_q == RW'(WINS - 1)) begin
          run_d  = '0;
          lock_d = 1'b1;
        end else begin
          run_d = run_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lock  <= 1'b0;
    end else begin
      run_q <= run_d;
      lock  <= lock_d;
    end
  end

  p_rise_on_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(done && pass));
  p_drop_on_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |=> !lock);
  p_quiet_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(lock));
endmodule

// File: rtl/quad_lock_det.sv
module quad_lock_det #(
  parameter int WIN_LOG2  = 4,
  parameter int LOCK_WINS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                osc_tick,
  input  logic                ref_in,
  input  logic                pol,
  input  logic [WIN_LOG2:0]   thr_acq,
  input  logic [WIN_LOG2:0]   thr_hold,
  output logic                tap_i,
  output logic                tap_q,
  output logic                pd_out,
  output logic                lock
);
  logic             quad_hit;
  logic             win_done;
  logic [WIN_LOG2:0] win_total;
  logic             pd_d;

  qld_johnson u_ring (
    .clk  (clk),
    .rst_n(rst_n),
    .step (osc_tick),
    .ph_i (tap_i),
    .ph_q (tap_q)
  );

  assign pd_d     = ref_in ^ tap_i;
  assign quad_hit = ref_in ^ tap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_out <= 1'b0;
    else        pd_out <= pd_d;
  end

  qld_window #(.W(WIN_LOG2)) u_win (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (quad_hit),
    .done (win_done),
    .total(win_total)
  );

  qld_lock_fsm #(.W(WIN_LOG2), .WINS(LOCK_WINS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (win_done),
    .total   (win_total),
    .pol     (pol),
    .thr_acq (thr_acq),
    .thr_hold(thr_hold),
    .lock    (lock)
  );

  p_pd_registered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pd_out == ($past(ref_in) ^ $past(tap_i))));
endmodule

// File: tb/quad_lock_det_bench.sv
module quad_lock_det_bench;
  localparam int W  = 4;
  localparam int M  = 3;
  localparam int WL = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic ref_in = 1'b0;
  logic pol = 1'b0;
  logic [W:0] thr_acq = '0;
  logic [W:0] thr_hold = '0;
  logic tap_i, tap_q, pd_out, lock;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  quad_lock_det #(.WIN_LOG2(W), .LOCK_WINS(M)) u_quad_lock_det (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ref_in(ref_in),
    .pol(pol), .thr_acq(thr_acq), .thr_hold(thr_hold),
    .tap_i(tap_i), .tap_q(tap_q), .pd_out(pd_out), .lock(lock));

  // bench model built from the requirements
  logic [1:0] m_ring;
  logic       m_pd, m_done, m_lock;
  int         m_phase, m_acc, m_total, m_run;

  function automatic bit passes(bit p, int total, int thr);
    return p ? (total > thr) : (total < thr);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ring <= 2'b00; m_pd <= 0; m_phase <= 0; m_acc <= 0;
      m_done <= 0; m_total <= 0; m_run <= 0; m_lock <= 0;
    end else begin
      int hit;
      hit = (ref_in ^ m_ring[1]) ? 1 : 0;
      if (osc_tick) m_ring <= {m_ring[0], ~m_ring[1]};
      m_pd <= ref_in ^ m_ring[0];
      if (m_phase == WL - 1) begin
        m_phase <= 0; m_acc <= 0; m_total <= m_acc + hit; m_done <= 1;
      end else begin
        m_phase <= m_phase + 1; m_acc <= m_acc + hit; m_done <= 0;
      end
      if (m_done) begin
        if (!passes(pol, m_total, m_lock ? int'(thr_hold) : int'(thr_acq))) begin
          m_lock <= 0; m_run <= 0;
        end else if (!m_lock) begin
          if (m_run == M - 1) begin m_lock <= 1; m_run <= 0; end
          else m_run <= m_run + 1;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison, sampled away from the clock edge
  always @(negedge clk) if (rst_n && !finished) begin
    check("R1 taps", {tap_q, tap_i}, m_ring);
    check("R2 pd_out", pd_out, m_pd);
    check("R6 lock", lock, m_lock);
  end

  // stimulus modes
  typedef enum int {MD_TRACK, MD_ANTI, MD_FREE, MD_FORCE} mode_e;
  mode_e mode = MD_TRACK;
  int noise = 0;      // out of 256
  int force_k = 0;
  int free_half = 5;
  int free_cnt = 0;
  bit free_lvl = 0;
  int tick_pct = 100;

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      osc_tick = ($urandom_range(99) < tick_pct);
      case (mode)
        MD_TRACK: ref_in = m_ring[1] ^ ($urandom_range(255) < noise);
        MD_ANTI:  ref_in = ~m_ring[1];
        MD_FORCE: ref_in = m_ring[1] ^ (m_phase < force_k);
        default: begin
          free_cnt++;
          if (free_cnt >= free_half) begin free_cnt = 0; free_lvl = ~free_lvl; end
          ref_in = free_lvl;
        end
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R8 tap_i", tap_i, 0);
    check("R8 tap_q", tap_q, 0);
    check("R8 pd_out", pd_out, 0);
    check("R8 lock", lock, 0);
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    pol = 0; thr_acq = 5'd3; thr_hold = 5'd6;
    do_reset();

    // R1: strobe held low freezes the divider
    tick_pct = 0; mode = MD_TRACK;
    step(1);
    step(5);
    check("R1 hold", {tap_q, tap_i}, 0);
    tick_pct = 100;

    // R6: clean tracking; windows pass from the first one
    do_reset();
    step(WL * 2 + 1);
    check("R6 early", lock, 0);
    step(WL * 2);
    check("R6 locked", lock, 1);

    // R5: in-band total keeps lock (hold threshold 6)
    mode = MD_FORCE; force_k = 4;
    step(WL * 4);
    check("R5 hold band", lock, 1);

    // R4/R7: total equal to threshold fails and drops lock
    force_k = 6;
    step(WL * 2);
    check("R4 equal fails", lock, 0);
    check("R7 dropped", lock, 0);

    // R5: same in-band total cannot reacquire
    force_k = 4;
    step(WL * 5);
    check("R5 no acquire", lock, 0);
    force_k = 2;
    step(WL * 5);
    check("R4 below acq", lock, 1);

    // R9: frequency error, threshold a quarter window
    thr_acq = 5'(WL / 4); thr_hold = 5'(WL / 4);
    mode = MD_FREE;
    for (int h = 3; h <= 7; h += 2) begin
      free_half = h;
      step(WL * 8);
      check("R9 slipping", lock, 0);
    end

    // R4: polarity many
    do_reset();
    pol = 1; thr_acq = 5'd13; thr_hold = 5'd10; mode = MD_ANTI;
    step(WL * 5);
    check("R4 pol many", lock, 1);
    mode = MD_TRACK; noise = 0;
    step(WL * 2);
    check("R7 pol many drop", lock, 0);

    // R3: random noise, random strobes, random thresholds
    pol = 0;
    for (int r = 0; r < 20; r++) begin
      noise = $urandom_range(40);
      tick_pct = 60 + $urandom_range(40);
      thr_acq = 5'($urandom_range(8));
      thr_hold = 5'($urandom_range(12));
      mode = MD_TRACK;
      step(WL * 4);
      check("R3 window model", lock, m_lock);
    end

    finish_run();
  end
endmodule